// File: doc/BRIEF.md
# Time-Multiplexed Synaptic Current Accumulator

This block produces, once per simulation timestep, the total synaptic current flowing into one post-synaptic neuron from a large set of afferent inputs. Every synapse holds its own signed current. On each timestep that current is scaled down by a fixed decay factor, which gives a single exponential decay. If the synapse's afferent fired in that timestep, the synapse's weight is then added. The new current is stored back and added into a running total.

A single multiplier and a single adder serve every synapse in turn, through a two-stage pipeline. The multiplier decays the stored current in the first stage. The adder applies the weight and accumulates in the second stage. Each synapse slot lasts two clock cycles. With the default of 500 synapses, a sweep takes 1001 cycles, which is 10 µs at 100 MHz and fits well inside a 0.1 ms timestep.

The surrounding system raises a one-cycle strobe at the start of each timestep, together with the afferent spike vector. It supplies weights from its own memory at the address the block presents. When the block pulses `done`, it reads the summed current.

Top module: `syn_current_accum`

## Requirements
- R1: After reset, `sumCurrent` is 0, `done` and `overrun` are low, and every stored synaptic current is 0.
- R2: Each synapse is updated as cur' = sat(floor(cur × DECAY_Q / 2^16) + (spike ? w : 0)). Here DECAY_Q is an unsigned Q0.16 factor, and cur and w are signed CUR_W-bit values.
- R3: At the end of a sweep, `sumCurrent` is the signed SUM_W-bit sum of the updated currents of all NUM_SYN synapses for that timestep.
- R4: `done` is high for exactly one cycle, in the cycle that follows clock edge 2·NUM_SYN+1 counted from the edge that accepts the strobe. It is low at every other time.
- R5: The edge that accepts a strobe clears `sumCurrent` to 0. After `done`, `sumCurrent` holds its value until the next accepted strobe.
- R6: The spike vector is captured on the edge that accepts the strobe. Changes to `spikeVec` during the sweep do not affect the result.
- R7: A strobe that arrives while a sweep is busy is not accepted. `overrun` then goes high for one cycle on the next cycle, and the running sweep and its result are unchanged. The sweep is busy from the accepting edge up to and including edge 2·NUM_SYN+1.
- R8: A strobe raised in the cycle where `done` is high is accepted as the start of a new timestep, and it raises no `overrun`.
- R9: A current that would pass the signed CUR_W-bit range saturates at +(2^(CUR_W-1)-1) or −2^(CUR_W-1).
- R10: `wgtAddr` steps through the synapse indices 0 to NUM_SYN-1 in ascending order during a sweep. Each index is held for two cycles, and `wgtData` for that index must be valid in the second of those two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepStrobe | input | 1 | Start-of-timestep pulse |
| spikeVec | input | NUM_SYN | Afferent spike bits for this timestep, bit i for synapse i |
| wgtAddr | output | $clog2(NUM_SYN) | Synapse index whose weight is requested |
| wgtData | input | CUR_W | Signed weight for `wgtAddr` |
| sumCurrent | output | SUM_W | Signed total synaptic current |
| done | output | 1 | One-cycle pulse when `sumCurrent` is complete |
| overrun | output | 1 | One-cycle pulse for a strobe that was ignored |

## Verification
The interesting collision is a strobe that lands right at the end of a sweep. A strobe raised one cycle before `done` falls on the final write-back edge, so `done` and `overrun` must pulse together and the finished sum must be intact. A strobe raised in the `done` cycle itself must instead start a new timestep cleanly, which the bench confirms by seeing the sum cleared and no `overrun`. Both cases are provoked on a small configuration, and each sum is compared with a bench model of the decay, weight and saturation arithmetic.

// File: rtl/syn_accum_pkg.sv
package syn_accum_pkg;

  // Strobes from the sequencer to the arithmetic datapath
  typedef struct packed {
    logic clrSum;    // accepted timestep start: clear the running total
    logic latchSpk;  // capture the afferent spike vector
    logic rdEn;      // first cycle of a synapse slot: read stored current
    logic stage1;    // second cycle: multiply by decay, capture weight
  } accStrobe_t;

endpackage

// File: rtl/syn_state_ram.sv
module syn_state_ram #(
  parameter int DEPTH  = 500,
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WIDTH-1:0] rdData,
  input  logic             wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WIDTH-1:0] wrData
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [DEPTH-1:0] written;

  // Storage array carries no reset; untouched entries read as zero
  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      written <= '0;
      rdData  <= '0;
    end else begin
      if (wrEn) written[wrAddr] <= 1'b1;
      if (rdEn) rdData <= written[rdAddr] ? mem[rdAddr] : '0;
    end
  end

endmodule

// File: rtl/syn_accum_ctrl.sv
module syn_accum_ctrl
  import syn_accum_pkg::*;
#(
  parameter int NUM_SYN = 500,
  parameter int IDX_W   = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepStrobe,
  output accStrobe_t       strobes,
  output logic [IDX_W-1:0] synIdx,
  output logic             busy,
  output logic             done,
  output logic             overrun
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SYN - 1);

  logic running;
  logic phase;     // 0: read slot, 1: multiply slot
  logic tailPend;  // last synapse is in stage 2
  logic accept;

  always_comb begin
    busy             = running | tailPend;
    accept           = stepStrobe & ~busy;
    strobes.clrSum   = accept;
    strobes.latchSpk = accept;
    strobes.rdEn     = running & ~phase;
    strobes.stage1   = running & phase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      phase    <= 1'b0;
      synIdx   <= '0;
      tailPend <= 1'b0;
      done     <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      overrun  <= stepStrobe & busy;
      done     <= tailPend;
      tailPend <= strobes.stage1 && (synIdx == LAST_IDX);
      if (accept) begin
        running <= 1'b1;
        phase   <= 1'b0;
        synIdx  <= '0;
      end else if (running) begin
        if (!phase) begin
          phase <= 1'b1;
        end else begin
          phase <= 1'b0;
          if (synIdx == LAST_IDX) running <= 1'b0;
          else                    synIdx  <= synIdx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/syn_accum_dp.sv
module syn_accum_dp
  import syn_accum_pkg::*;
#(
  parameter int          NUM_SYN = 500,
  parameter int          IDX_W   = 9,
  parameter int          CUR_W   = 16,
  parameter int          SUM_W   = 26,
  parameter int          DECAY_W = 16,
  parameter int unsigned DECAY_Q = 62259
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  accStrobe_t              strobes,
  input  logic [IDX_W-1:0]        synIdx,
  input  logic [NUM_SYN-1:0]      spikeVec,
  input  logic signed [CUR_W-1:0] wgtData,
  output logic signed [SUM_W-1:0] sumCurrent
);

  localparam int PROD_W = CUR_W + DECAY_W + 1;
  localparam logic signed [DECAY_W:0] DECAY_S = (DECAY_W + 1)'(DECAY_Q);
  localparam logic signed [CUR_W-1:0] CUR_MAX = {1'b0, {(CUR_W-1){1'b1}}};
  localparam logic signed [CUR_W-1:0] CUR_MIN = {1'b1, {(CUR_W-1){1'b0}}};

  logic [NUM_SYN-1:0]      spkLat;
  logic [CUR_W-1:0]        rdData;
  logic signed [PROD_W-1:0] prodFull;
  logic signed [PROD_W-1:0] prodShift;
  logic signed [CUR_W-1:0] decReg;
  logic signed [CUR_W-1:0] wReg;
  logic                    spkReg;
  logic [IDX_W-1:0]        s2Addr;
  logic                    s2Valid;
  logic signed [CUR_W-1:0] addend;
  logic signed [CUR_W:0]   rawSum;
  logic signed [CUR_W-1:0] newCur;

  syn_state_ram #(
    .DEPTH (NUM_SYN),
    .WIDTH (CUR_W),
    .ADDR_W(IDX_W)
  ) u_state (
    .clk   (clk),
    .rstN  (rstN),
    .rdEn  (strobes.rdEn),
    .rdAddr(synIdx),
    .rdData(rdData),
    .wrEn  (s2Valid),
    .wrAddr(s2Addr),
    .wrData(newCur)
  );

  // Stage 1: shared multiplier, floor scaling by the Q0.16 factor
  always_comb begin
    prodFull  = $signed(rdData) * DECAY_S;
    prodShift = prodFull >>> DECAY_W;
  end

  // Stage 2: shared adder with saturation
  always_comb begin
    addend = spkReg ? wReg : '0;
    rawSum = {decReg[CUR_W-1], decReg} + {addend[CUR_W-1], addend};
    if (rawSum[CUR_W] != rawSum[CUR_W-1])
      newCur = rawSum[CUR_W] ? CUR_MIN : CUR_MAX;
    else
      newCur = rawSum[CUR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spkLat     <= '0;
      decReg     <= '0;
      wReg       <= '0;
      spkReg     <= 1'b0;
      s2Addr     <= '0;
      s2Valid    <= 1'b0;
      sumCurrent <= '0;
    end else begin
      s2Valid <= strobes.stage1;
      if (strobes.latchSpk) spkLat <= spikeVec;
      if (strobes.stage1) begin
        decReg <= prodShift[CUR_W-1:0];
        wReg   <= wgtData;
        spkReg <= spkLat[synIdx];
        s2Addr <= synIdx;
      end
      if (strobes.clrSum)
        sumCurrent <= '0;
      else if (s2Valid)
        sumCurrent <= sumCurrent + {{(SUM_W-CUR_W){newCur[CUR_W-1]}}, newCur};
    end
  end

endmodule

// File: rtl/syn_current_accum.sv
module syn_current_accum
  import syn_accum_pkg::*;
#(
  parameter int          NUM_SYN = 500,
  parameter int          CUR_W   = 16,
  parameter int          SUM_W   = 26,
  parameter int          DECAY_W = 16,
  parameter int unsigned DECAY_Q = 62259,
  localparam int         IDX_W   = $clog2(NUM_SYN)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    stepStrobe,
  input  logic [NUM_SYN-1:0]      spikeVec,
  output logic [IDX_W-1:0]        wgtAddr,
  input  logic signed [CUR_W-1:0] wgtData,
  output logic signed [SUM_W-1:0] sumCurrent,
  output logic                    done,
  output logic                    overrun
);

  accStrobe_t       strobes;
  logic [IDX_W-1:0] synIdx;
  logic             ctrlBusy;

  syn_accum_ctrl #(
    .NUM_SYN(NUM_SYN),
    .IDX_W  (IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .stepStrobe(stepStrobe),
    .strobes   (strobes),
    .synIdx    (synIdx),
    .busy      (ctrlBusy),
    .done      (done),
    .overrun   (overrun)
  );

  syn_accum_dp #(
    .NUM_SYN(NUM_SYN),
    .IDX_W  (IDX_W),
    .CUR_W  (CUR_W),
    .SUM_W  (SUM_W),
    .DECAY_W(DECAY_W),
    .DECAY_Q(DECAY_Q)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .synIdx    (synIdx),
    .spikeVec  (spikeVec),
    .wgtData   (wgtData),
    .sumCurrent(sumCurrent)
  );

  assign wgtAddr = synIdx;

endmodule

// File: rtl/syn_accum_chk.sv
module syn_accum_chk #(
  parameter int NUM_SYN = 500,
  parameter int IDX_W   = 9,
  parameter int SUM_W   = 26
) (
  input logic             clk,
  input logic             rstN,
  input logic             stepStrobe,
  input logic             busy,
  input logic             done,
  input logic             overrun,
  input logic [IDX_W-1:0] wgtAddr,
  input logic [SUM_W-1:0] sumCurrent
);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> $past(stepStrobe && busy));

  // R7
  overrun_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepStrobe && busy) |=> overrun);

  // R5
  sum_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepStrobe && !busy) |=> (sumCurrent == '0));

  // R5
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !stepStrobe) |=> $stable(sumCurrent));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R10
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(wgtAddr) < NUM_SYN);

endmodule

bind syn_current_accum syn_accum_chk #(
  .NUM_SYN(NUM_SYN),
  .IDX_W  (IDX_W),
  .SUM_W  (SUM_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .stepStrobe(stepStrobe),
  .busy      (ctrlBusy),
  .done      (done),
  .overrun   (overrun),
  .wgtAddr   (wgtAddr),
  .sumCurrent(sumCurrent)
);

// File: tb/sim_syn_current_accum.sv
`timescale 1ns/1ps
module sim_syn_current_accum;

  localparam int          N     = 8;
  localparam int          CW    = 16;
  localparam int          SW    = 26;
  localparam int unsigned DQ    = 49152;  // 0.75 in Q0.16
  localparam int          AW    = $clog2(N);
  localparam int          SWEEP = 2 * N + 2;  // negedge index where done is seen

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 stepStrobe = 1'b0;
  logic [N-1:0]         spikeVec = '0;
  logic [AW-1:0]        wgtAddr;
  logic signed [CW-1:0] wgtData;
  logic signed [SW-1:0] sumCurrent;
  logic                 done;
  logic                 overrun;

  logic signed [CW-1:0] wmem [N];
  longint               model [N];
  int                   checks = 0;
  int                   errors = 0;
  bit                   finished = 1'b0;

  always #2 clk = ~clk;

  assign wgtData = wmem[wgtAddr];

  syn_current_accum #(
    .NUM_SYN(N),
    .CUR_W  (CW),
    .SUM_W  (SW),
    .DECAY_W(16),
    .DECAY_Q(DQ)
  ) u0 (
    .clk       (clk),
    .rstN      (rstN),
    .stepStrobe(stepStrobe),
    .spikeVec  (spikeVec),
    .wgtAddr   (wgtAddr),
    .wgtData   (wgtData),
    .sumCurrent(sumCurrent),
    .done      (done),
    .overrun   (overrun)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Advance the model by one timestep and return the expected total
  function automatic longint stepModel(input logic [N-1:0] spk);
    longint total = 0;
    for (int i = 0; i < N; i++) begin
      longint v = (model[i] * longint'(DQ)) >>> 16;
      if (spk[i]) v += longint'(wmem[i]);
      if (v > 32767)  v = 32767;
      if (v < -32768) v = -32768;
      model[i] = v;
      total += v;
    end
    return total;
  endfunction

  // One timestep. midAt: negedge index at which a stray strobe is raised (0 = none).
  // preStarted: strobe already raised by the previous call.
  // chainNext: raise the next strobe in the done cycle.
  task automatic runStep(input logic [N-1:0] spk, input string sumReq, input int midAt,
                         input bit changeMid, input bit preStarted, input bit chainNext,
                         input logic [N-1:0] nextSpk);
    longint expSum = stepModel(spk);
    if (!preStarted) begin
      @(negedge clk);
      stepStrobe = 1'b1;
      spikeVec   = spk;
    end
    @(negedge clk);  // negedge 1 after the accepting edge
    stepStrobe = 1'b0;
    chk("R5 sum cleared on accept", longint'(sumCurrent), 0);
    chk("R8 no overrun on accept", longint'(overrun), 0);
    for (int k = 1; k <= SWEEP; k++) begin
      if (k > 1) @(negedge clk);
      if (k <= 2 * N) chk("R10 weight address order", longint'(wgtAddr), longint'((k - 1) / 2));
      if (midAt != 0 && k == midAt + 1) chk("R7 overrun pulse", longint'(overrun), 1);
      else if (k > 1) chk("R7 overrun idle", longint'(overrun), 0);
      if (k < SWEEP) chk("R4 done low during sweep", longint'(done), 0);
      else begin
        chk("R4 done at sweep end", longint'(done), 1);
        chk(sumReq, longint'(sumCurrent), expSum);
      end
      if (changeMid && k == 3) spikeVec = ~spk;  // R6
      stepStrobe = (midAt != 0 && k == midAt);
      if (chainNext && k == SWEEP) begin
        stepStrobe = 1'b1;
        spikeVec   = nextSpk;
      end
    end
    if (!chainNext) begin
      repeat (3) @(negedge clk);
      chk("R5 sum held after done", longint'(sumCurrent), expSum);
      chk("R4 done stays low", longint'(done), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wmem[0] = 16'sd1200;  wmem[1] = -16'sd700;
    wmem[2] = 16'sd30000; wmem[3] = -16'sd30000;
    wmem[4] = 16'sd5;     wmem[5] = 16'sd32767;
    wmem[6] = -16'sd32768; wmem[7] = 16'sd300;
    for (int i = 0; i < N; i++) model[i] = 0;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset sum", longint'(sumCurrent), 0);
    chk("R1 reset done", longint'(done), 0);
    chk("R1 reset overrun", longint'(overrun), 0);

    // R1: zero state, no spikes
    runStep('0, "R1 stored currents zero", 0, 0, 0, 0, '0);
    // R3 with a stray strobe early in the sweep (R7)
    runStep('1, "R3 all spikes sum", 5, 0, 0, 0, '0);
    // R2: pure decay
    runStep('0, "R2 decay only", 0, 0, 0, 0, '0);
    // R6: spike vector toggled mid-sweep
    runStep(8'b1010_0101, "R6 spikes latched", 0, 1, 0, 0, '0);
    // R7 collision: stray strobe on the final write-back edge, then chain (R8)
    runStep('1, "R7 sum intact on collision", 2 * N + 1, 0, 0, 1, '1);
    runStep('1, "R8 chained step sum", 0, 0, 1, 0, '0);
    // R9: repeated spikes drive large weights into saturation
    runStep('1, "R9 saturated sum", 0, 0, 0, 0, '0);
    runStep('1, "R9 saturated sum hold", 0, 0, 0, 0, '0);
    // R2: decay tail, mixed pattern
    runStep(8'b0100_0010, "R2 mixed pattern", 3, 0, 0, 0, '0);
    runStep('0, "R2 decay tail", 0, 0, 0, 0, '0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule